// File: doc/BRIEF.md
# Eight-bit Condition Flag Unit

This block produces and holds the condition flags of an 8-bit accumulator ALU. The arithmetic datapath sits outside: each cycle it hands this block an operation class, the two operands, the carry-in it used and the 8-bit result it produced. From these the block derives Sign, Zero, Carry, half-carry (AC) and Parity, and writes them into a registered flag byte. A per-flag write enable masks that update.

A separate operation class restores the whole flag byte from a data input. This is the path used when a saved status word is popped back together with the accumulator. Through it, software can force any combination of the five flags. The block has no overflow flag. Sign is always the top bit of the result, even when a signed addition overflows.

Top module: `flag_unit`

## Requirements
- R1: While reset is high, and on the first clock after it, the flag byte reads 02h.
- R2: The flag byte layout is S = bit 7, Z = bit 6, AC = bit 4, P = bit 2, C = bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1, including after a restore.
- R3: S equals bit 7 of the result. Signed overflow does not change S and is not reported in any other flag (7Fh + 01h gives flag byte 92h).
- R4: Z is set exactly when the result is 00h.
- R5: P is set when the result holds an even number of one bits. A result of 00h counts as even.
- R6: Add (op 1) sets C to the carry out of bit 7 of opa + opb + cin, and AC to the carry out of bit 3 of the same sum.
- R7: Subtract/compare (op 2) sets C to the borrow of opa − opb − cin, and AC to the borrow into bit 4 (low nibble of opa less than low nibble of opb plus cin).
- R8: AND (op 3) clears C and sets AC. OR/XOR (op 4) clears both C and AC. The operands have no effect on either flag.
- R9: Increment (op 5) and decrement (op 6) update S, Z, P and AC but leave C unchanged. For increment, AC is set when the low nibble of opa is Fh. For decrement, AC is set when it is 0h.
- R10: Restore (op 7) loads bits 7, 6, 4, 2 and 0 of the load input into the flag byte. The write enables are ignored for this operation.
- R11: Write-enable bits [4..0] gate S, Z, AC, P and C, in that order. A flag whose enable bit is 0 keeps its value.
- R12: No-op (op 0) leaves the flag byte unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation class: 0 nop, 1 add, 2 sub/cmp, 3 and, 4 or/xor, 5 inc, 6 dec, 7 restore |
| opa_i | input | 8 | First operand (for inc/dec, the value before the step) |
| opb_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry/borrow in used by the datapath |
| result_i | input | 8 | Result produced by the datapath |
| we_i | input | 5 | Per-flag write enable {S,Z,AC,P,C} |
| load_i | input | 8 | Flag byte to restore |
| flags_o | output | 8 | Registered flag byte |

## Verification
Add and subtract are driven with every one of the 65,536 operand pairs, with carry-in taken from the low bit of the first operand. This sweep separates carry from borrow, catches nibble-boundary errors in AC, and covers every parity count. Directed cases then cover the remaining behaviour: a signed-overflow sum shows that Sign is not corrected, and a zero result shows the even-parity rule. Logical operations are run after a restore has set C, which shows that C is actually cleared and not merely left unset. Inc and dec run at the nibble edges with C set beforehand, which shows that C is held. Enable masks applied one flag at a time show that the update is gated per flag.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int DATA_W   = 8;
  localparam int FLAG_CNT = 5;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_ORX  = 3'd4,
    OP_INC  = 3'd5,
    OP_DEC  = 3'd6,
    OP_LOAD = 3'd7
  } op_e;

  // bit positions in the flag byte (decoded by software on restore)
  localparam int POS_S  = 7;
  localparam int POS_Z  = 6;
  localparam int POS_AC = 4;
  localparam int POS_P  = 2;
  localparam int POS_C  = 0;

  // write-enable bit order
  localparam int WE_S  = 4;
  localparam int WE_Z  = 3;
  localparam int WE_AC = 2;
  localparam int WE_P  = 1;
  localparam int WE_C  = 0;

  localparam logic [DATA_W-1:0] FIXED_MASK = 8'h2A;
  localparam logic [DATA_W-1:0] FIXED_VAL  = 8'h02;
endpackage

// File: rtl/flag_szp.sv
module flag_szp #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  output logic         s_o,
  output logic         z_o,
  output logic         p_o
);
  logic [W:0] par_chain;

  assign par_chain[0] = 1'b1;
  generate
    for (genvar i = 0; i < W; i++) begin : g_par
      assign par_chain[i+1] = par_chain[i] ^ res_i[i];
    end
  endgenerate

  assign s_o = res_i[W-1];
  assign z_o = (res_i == '0);
  assign p_o = par_chain[W];
endmodule

// File: rtl/flag_arith.sv
module flag_arith
  import flag_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic         c_o,
  output logic         c_upd_o,
  output logic         ac_o
);
  localparam int NW = W / 2;

  logic [W:0]  full_add, full_sub;
  logic [NW:0] lo_add, lo_sub;

  always_comb begin
    full_add = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    full_sub = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    lo_add   = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + {{NW{1'b0}}, cin_i};
    lo_sub   = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]} - {{NW{1'b0}}, cin_i};
  end

  always_comb begin
    c_o     = 1'b0;
    c_upd_o = 1'b1;
    ac_o    = 1'b0;
    unique case (op_i)
      OP_ADD: begin c_o = full_add[W]; ac_o = lo_add[NW]; end
      OP_SUB: begin c_o = full_sub[W]; ac_o = lo_sub[NW]; end
      OP_AND: begin c_o = 1'b0; ac_o = 1'b1; end
      OP_ORX: begin c_o = 1'b0; ac_o = 1'b0; end
      OP_INC: begin c_upd_o = 1'b0; ac_o = &a_i[NW-1:0]; end
      OP_DEC: begin c_upd_o = 1'b0; ac_o = ~|a_i[NW-1:0]; end
      default: c_upd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_pkg::*;
#(
  parameter int W  = 8,
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  op_e           op_i,
  input  logic [NF-1:0] we_i,
  input  logic          s_i,
  input  logic          z_i,
  input  logic          ac_i,
  input  logic          p_i,
  input  logic          c_i,
  input  logic          c_upd_i,
  input  logic [W-1:0]  load_i,
  output logic [W-1:0]  flag_q
);
  logic [W-1:0] flag_d;

  always_comb begin
    flag_d = flag_q;
    if (op_i == OP_LOAD) begin
      flag_d = (load_i & ~FIXED_MASK) | FIXED_VAL;
    end else if (op_i != OP_NOP) begin
      if (we_i[WE_S])             flag_d[POS_S]  = s_i;
      if (we_i[WE_Z])             flag_d[POS_Z]  = z_i;
      if (we_i[WE_AC])            flag_d[POS_AC] = ac_i;
      if (we_i[WE_P])             flag_d[POS_P]  = p_i;
      if (we_i[WE_C] && c_upd_i)  flag_d[POS_C]  = c_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= FIXED_VAL;
    else     flag_q <= flag_d;
  end

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & FIXED_MASK) == FIXED_VAL)); // R2
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NOP) |=> $stable(flag_q)); // R12
  AST_INCDEC_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_INC || op_i == OP_DEC) |=> $stable(flag_q[POS_C])); // R9
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_i != OP_LOAD && we_i == '0) |=> $stable(flag_q)); // R11
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int NF = FLAG_CNT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  input  logic          cin_i,
  input  logic [W-1:0]  result_i,
  input  logic [NF-1:0] we_i,
  input  logic [W-1:0]  load_i,
  output logic [W-1:0]  flags_o
);
  op_e  op;
  logic s_w, z_w, p_w, c_w, c_upd_w, ac_w;

  assign op = op_e'(op_i);

  flag_szp #(.W(W)) u_szp (
    .res_i (result_i),
    .s_o   (s_w),
    .z_o   (z_w),
    .p_o   (p_w)
  );

  flag_arith #(.W(W)) u_arith (
    .op_i    (op),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .cin_i   (cin_i),
    .c_o     (c_w),
    .c_upd_o (c_upd_w),
    .ac_o    (ac_w)
  );

  flag_reg #(.W(W), .NF(NF)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op),
    .we_i    (we_i),
    .s_i     (s_w),
    .z_i     (z_w),
    .ac_i    (ac_w),
    .p_i     (p_w),
    .c_i     (c_w),
    .c_upd_i (c_upd_w),
    .load_i  (load_i),
    .flag_q  (flags_o)
  );

  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_AND || op == OP_ORX) && we_i[WE_C]) |=> !flags_o[POS_C]); // R8
  AST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op != OP_NOP && op != OP_LOAD && we_i[WE_Z])
      |=> (flags_o[POS_Z] == ($past(result_i) == '0))); // R4
  AST_SIGN: assert property (@(posedge clk) disable iff (rst)
    (op != OP_NOP && op != OP_LOAD && we_i[WE_S])
      |=> (flags_o[POS_S] == $past(result_i[W-1]))); // R3
  AST_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (flags_o[POS_S] == $past(load_i[POS_S])
                         && flags_o[POS_C] == $past(load_i[POS_C]))); // R10
endmodule

// File: tb/flag_unit_bench.sv
module flag_unit_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] op;
  logic [7:0] opa, opb, res, ld;
  logic       cin;
  logic [4:0] we;
  logic [7:0] flags;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flag_unit u_flag_unit (
    .clk(clk), .rst(rst), .op_i(op), .opa_i(opa), .opb_i(opb), .cin_i(cin),
    .result_i(res), .we_i(we), .load_i(ld), .flags_o(flags)
  );

  function automatic logic [7:0] pack(input logic s, z, ac, p, c);
    return {s, z, 1'b0, ac, 1'b0, p, 1'b1, c};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: flags=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic apply(input logic [2:0] o, input logic [7:0] a, b,
                       input logic c, input logic [7:0] r, input logic [4:0] w,
                       input logic [7:0] l);
    op = o; opa = a; opb = b; cin = c; res = r; we = w; ld = l;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    apply(3'd7, 8'h00, 8'h00, 1'b0, 8'h00, 5'h1F, 8'hFF);
    chk("R1 during reset", flags, 8'h02);
    apply(3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 5'h1F, 8'h00);
    rst = 1'b0;
    apply(3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 5'h1F, 8'h00);
    chk("R1 after reset", flags, 8'h02);
  endtask

  task automatic t_add_all;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        logic [8:0] sum;
        logic [4:0] lo;
        logic c;
        c   = a[0];
        sum = 9'(a) + 9'(b) + 9'(c);
        lo  = 5'(a & 15) + 5'(b & 15) + 5'(c);
        apply(3'd1, 8'(a), 8'(b), c, sum[7:0], 5'h1F, 8'h00);
        chk("R6 add sweep", flags,
            pack(sum[7], sum[7:0] == 0, lo[4], ~^sum[7:0], sum[8]));
      end
    end
  endtask

  task automatic t_sub_all;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        logic [7:0] d;
        logic c, bor, hbor;
        c    = a[0];
        d    = 8'(a - b - int'(c));
        bor  = a < (b + int'(c));
        hbor = (a & 15) < ((b & 15) + int'(c));
        apply(3'd2, 8'(a), 8'(b), c, d, 5'h1F, 8'h00);
        chk("R7 sub sweep", flags, pack(d[7], d == 0, hbor, ~^d, bor));
      end
    end
  endtask

  task automatic t_sign_parity;
    apply(3'd1, 8'h7F, 8'h01, 1'b0, 8'h80, 5'h1F, 8'h00);
    chk("R3 signed overflow", flags, 8'h92);
    apply(3'd2, 8'h05, 8'h05, 1'b0, 8'h00, 5'h1F, 8'h00);
    chk("R5 R4 zero is even", flags, 8'h46);
  endtask

  task automatic t_logic;
    apply(3'd7, 8'h00, 8'h00, 1'b0, 8'h00, 5'h00, 8'hFF);
    apply(3'd3, 8'hF0, 8'h0F, 1'b1, 8'h00, 5'h1F, 8'h00);
    chk("R8 and", flags, 8'h56);
    apply(3'd7, 8'h00, 8'h00, 1'b0, 8'h00, 5'h00, 8'hFF);
    apply(3'd4, 8'h81, 8'h01, 1'b1, 8'h81, 5'h1F, 8'h00);
    chk("R8 or/xor", flags, 8'h86);
  endtask

  task automatic t_incdec;
    apply(3'd7, 8'h00, 8'h00, 1'b0, 8'h00, 5'h00, 8'h01);
    apply(3'd5, 8'h0F, 8'hFF, 1'b0, 8'h10, 5'h1F, 8'h00);
    chk("R9 inc keeps C", flags, 8'h13);
    apply(3'd7, 8'h00, 8'h00, 1'b0, 8'h00, 5'h00, 8'h00);
    apply(3'd6, 8'h00, 8'h00, 1'b1, 8'hFF, 5'h1F, 8'h00);
    chk("R9 dec keeps C", flags, 8'h96);
  endtask

  task automatic t_restore;
    apply(3'd7, 8'h00, 8'h00, 1'b0, 8'h00, 5'h00, 8'hFF);
    chk("R10 R2 restore all ones", flags, 8'hD7);
    apply(3'd7, 8'hFF, 8'hFF, 1'b1, 8'hFF, 5'h1F, 8'h28);
    chk("R10 R2 restore fixed bits", flags, 8'h02);
  endtask

  task automatic t_enables;
    apply(3'd7, 8'h00, 8'h00, 1'b0, 8'h00, 5'h00, 8'h00);
    apply(3'd1, 8'hFF, 8'h01, 1'b0, 8'h00, 5'b00001, 8'h00);
    chk("R11 only C", flags, 8'h03);
    apply(3'd1, 8'h00, 8'h00, 1'b0, 8'h00, 5'b01000, 8'h00);
    chk("R11 only Z", flags, 8'h43);
    apply(3'd1, 8'h80, 8'h80, 1'b0, 8'h00, 5'b00000, 8'h00);
    chk("R11 none", flags, 8'h43);
  endtask

  task automatic t_nop;
    apply(3'd0, 8'hFF, 8'hFF, 1'b1, 8'h80, 5'h1F, 8'hFF);
    chk("R12 nop", flags, 8'h43);
  endtask

  initial begin
    rst = 1'b1; op = 3'd0; opa = 8'h00; opb = 8'h00; cin = 1'b0;
    res = 8'h00; we = 5'h00; ld = 8'h00;
    @(negedge clk);
    t_reset();
    t_sign_parity();
    t_logic();
    t_incdec();
    t_restore();
    t_enables();
    t_nop();
    t_add_all();
    t_sub_all();
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule